// File: doc/BRIEF.md
# Periodic Compare Timer

This block keeps a 16-bit up-counter running freely from a divided bus clock. One compare channel sits beside it. When the counter steps onto the value held in the compare register, a sticky match flag is raised. If the matching mask bit is set, the flag also drives an interrupt line. Software builds a steady periodic interrupt with a short handler. The handler adds a fixed period constant to the compare register and then clears the flag by writing a one to it.

A small word-wide register port gives access to the counter (read only), the compare value, the flag, the mask and the prescale selector. The prescale selector changes how fast the counter steps, so the same period constant gives interrupt rates that differ by up to a factor of sixteen. For example, with a 12.5829 MHz crystal and the bus clock at a quarter of it, a period of 0x999A at divide-by-1 gives one interrupt every 12.5 ms.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter reads 0x0000, the compare register reads 0xFFFF, the flag, mask and prescale registers read 0, and `irq` is low.
- R2: With prescale 0 the counter advances by one on every clock and wraps from 0xFFFF to 0x0000.
- R3: The prescale register (address 4, bits 1:0) selects the counter step rate: 0 steps every clock, 1 every 4 clocks, 2 every 8 clocks, 3 every 16 clocks.
- R4: In the clock edge where the counter takes the value held in the compare register (address 1), the flag (bit 4 of address 2, value 0x0010) becomes 1 and stays set.
- R5: Writing address 2 with bit 4 set clears the flag, and zero bits leave it unchanged. A match in the same edge as a clearing write wins, so the flag stays 1.
- R6: `irq` is high exactly while the flag and mask bit 4 (address 3, value 0x0010) are both set, and it stays high until one of them is cleared.
- R7: A compare write in the same edge as a match still sets the flag for that match, and the written value is used for the next comparison.
- R8: Adding a period P to the compare register after a match gives the next match exactly P counter steps later, also when the sum wraps past 0xFFFF.
- R9: Writes to the counter address (address 0) are ignored. The counter keeps its own count.
- R10: Reads of addresses 5 to 7 return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register address: 0 count, 1 compare, 2 flag, 3 mask, 4 prescale |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, flag AND mask |

## Verification
The counter rate is measured over windows that are whole multiples of each divide ratio. This makes the step count exact whatever the phase of the prescaler, so each of the four selector codes is told apart from the others.

Compare matches are placed a few steps ahead of the current count. The flag is then sampled one cycle before and at the expected edge, which separates a correct match from one that fires a cycle early or late. Colliding writes are placed in that same edge: a flag clear, or a compare update, lands exactly on a match. This shows whether set wins over clear and whether the old or the new compare value governs.

A two-period run with the 0x999A reload crosses the counter wrap. It shows that the modular addition keeps the period exact.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W   = 3;
    localparam int PSEL_W   = 2;
    localparam int DIV_W    = 4;
    localparam int FLAG_BIT = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_COUNT = 3'd0,
        REG_CMP   = 3'd1,
        REG_FLAG  = 3'd2,
        REG_MASK  = 3'd3,
        REG_PRESC = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic      cmp_wr;
        logic      flag_clr;
        logic      mask_wr;
        logic      presc_wr;
    } wr_dec_t;

    // terminal count of the divider for each selector code
    function automatic logic [DIV_W-1:0] presc_limit(input logic [PSEL_W-1:0] sel);
        logic [DIV_W-1:0] lim;
        case (sel)
            2'd0:    lim = 4'd0;
            2'd1:    lim = 4'd3;
            2'd2:    lim = 4'd7;
            default: lim = 4'd15;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PSEL_W-1:0] sel,
    output logic              tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = presc_limit(sel);
        // >= keeps the divider sane when the selector shrinks mid-count
        tick = (div_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);

    // modular increment: 0xFFFF rolls to 0
    always_comb cnt_nxt = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= cnt_nxt;
    end

endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cmp_q,
    output logic             flag_q
);

    logic match;

    // match is judged on the value the counter is about to take,
    // against the compare value held before any write in this edge
    always_comb match = tick && (cnt_nxt == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '1;
            flag_q <= 1'b0;
        end else begin
            if (cmp_wr) cmp_q <= cmp_wdata;
            if (match)         flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    localparam int FLAG_PAD_HI = CNT_W - FLAG_BIT - 1;

    wr_dec_t           dec;
    logic              tick;
    logic [PSEL_W-1:0] psel_q;
    logic              mask_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [CNT_W-1:0]  cmp_q;
    logic              flag_q;

    always_comb begin
        dec          = '0;
        dec.cmp_wr   = bus_we && (bus_addr == REG_CMP);
        dec.flag_clr = bus_we && (bus_addr == REG_FLAG) && bus_wdata[FLAG_BIT];
        dec.mask_wr  = bus_we && (bus_addr == REG_MASK);
        dec.presc_wr = bus_we && (bus_addr == REG_PRESC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psel_q <= '0;
            mask_q <= 1'b0;
        end else begin
            if (dec.presc_wr) psel_q <= bus_wdata[PSEL_W-1:0];
            if (dec.mask_wr)  mask_q <= bus_wdata[FLAG_BIT];
        end
    end

    tmr_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .sel  (psel_q),
        .tick (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    tmr_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cnt_nxt   (cnt_nxt),
        .cmp_wr    (dec.cmp_wr),
        .cmp_wdata (bus_wdata),
        .flag_clr  (dec.flag_clr),
        .cmp_q     (cmp_q),
        .flag_q    (flag_q)
    );

    always_comb begin
        case (bus_addr)
            REG_COUNT: bus_rdata = cnt_q;
            REG_CMP:   bus_rdata = cmp_q;
            REG_FLAG:  bus_rdata = {{FLAG_PAD_HI{1'b0}}, flag_q, {FLAG_BIT{1'b0}}};
            REG_MASK:  bus_rdata = {{FLAG_PAD_HI{1'b0}}, mask_q, {FLAG_BIT{1'b0}}};
            REG_PRESC: bus_rdata = {{(CNT_W-PSEL_W){1'b0}}, psel_q};
            default:   bus_rdata = '0;
        endcase
    end

    always_comb irq = flag_q & mask_q;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic [1:0]    psel,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] cmp,
    input logic          flag,
    input logic          mask,
    input logic          irq,
    input logic          bus_we,
    input logic [2:0]    bus_addr,
    input logic [CW-1:0] bus_wdata
);

    logic [CW-1:0] cnt_inc;
    always_comb cnt_inc = cnt + 1'b1;

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == $past(cnt_inc)));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    // R3
    presc_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && psel == 2'd3) |=> (!tick || psel != 2'd3));

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (cnt == $past(cmp)));

    // R5
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !(bus_we && bus_addr == 3'd2 && bus_wdata[4])) |=> flag);

    // R6
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && mask));

endmodule

bind cmp_timer tmr_checker #(.CW(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .psel      (psel_q),
    .cnt       (cnt_q),
    .cmp       (cmp_q),
    .flag      (flag_q),
    .mask      (mask_q),
    .irq       (irq),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/tb_cmp_timer.sv
`timescale 1ns/100ps
module tb_cmp_timer;

    localparam logic [2:0] A_CNT = 3'd0, A_CMP = 3'd1, A_FLG = 3'd2,
                           A_MSK = 3'd3, A_PRE = 3'd4;
    localparam logic [15:0] PERIOD = 16'h999A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq;

    always #2 clk = ~clk;

    cmp_timer dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        logic        on_irq;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_total = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            wait (q.size() != 0);
            begin
                item_t it;
                logic [15:0] act;
                it  = q.pop_front();
                act = it.on_irq ? {15'd0, irq} : bus_rdata;
                n_total++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // driver side: queue a register read expectation (inside a low phase)
    task automatic chk_reg(input logic [2:0] a, input logic [15:0] e, input string tag);
        item_t it;
        bus_addr = a;
        #0.1;
        it.on_irq = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
        #0.1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.on_irq = 1'b1; it.exp = {15'd0, e}; it.tag = tag;
        q.push_back(it);
        #0.1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        bus_addr = a;
        #0.1;
        v = bus_rdata;
    endtask

    // write lands on the next rising edge; returns at the following low phase
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [15:0] c;
        logic [15:0] base;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        chk_reg(A_CNT, 16'h0000, "R1 count");
        chk_reg(A_CMP, 16'hFFFF, "R1 compare");
        chk_reg(A_FLG, 16'h0000, "R1 flag");
        @(negedge clk);
        chk_reg(A_MSK, 16'h0000, "R1 mask");
        chk_reg(A_PRE, 16'h0000, "R1 prescale");
        chk_irq(1'b0, "R1 irq");

        // R2 one step per clock
        @(negedge clk);
        rd(A_CNT, c);
        repeat (50) @(negedge clk);
        chk_reg(A_CNT, c + 16'd50, "R2 rate div1");

        // R9 count writes ignored
        @(negedge clk);
        rd(A_CNT, c);
        wr(A_CNT, 16'h1234);
        chk_reg(A_CNT, c + 16'd1, "R9 count write ignored");

        // R10 unused addresses
        chk_reg(3'd5, 16'h0000, "R10 addr5");
        chk_reg(3'd7, 16'h0000, "R10 addr7");

        // R3 each divide ratio over 160 clocks
        for (int s = 1; s < 4; s++) begin
            @(negedge clk);
            wr(A_PRE, 16'(s));
            chk_reg(A_PRE, 16'(s), "R3 prescale readback");
            repeat (20) @(negedge clk);
            rd(A_CNT, c);
            repeat (160) @(negedge clk);
            chk_reg(A_CNT, c + ((s == 1) ? 16'd40 : (s == 2) ? 16'd20 : 16'd10),
                    "R3 divided rate");
        end
        @(negedge clk);
        wr(A_PRE, 16'd0);

        // R4 match ten steps ahead
        rd(A_CNT, c);
        wr(A_CMP, c + 16'd10);
        repeat (8) @(negedge clk);
        chk_reg(A_FLG, 16'h0000, "R4 flag before match");
        @(negedge clk);
        chk_reg(A_FLG, 16'h0010, "R4 flag at match");
        chk_irq(1'b0, "R6 irq masked");
        @(negedge clk);
        wr(A_MSK, 16'h0010);
        chk_irq(1'b1, "R6 irq enabled");
        wr(A_FLG, 16'h0000);
        chk_reg(A_FLG, 16'h0010, "R5 zero write keeps flag");
        chk_irq(1'b1, "R6 irq held");
        wr(A_FLG, 16'h0010);
        chk_reg(A_FLG, 16'h0000, "R5 one clears flag");
        chk_irq(1'b0, "R6 irq drops");

        // R7 compare rewritten in the match edge, then R5 collision
        @(negedge clk);
        rd(A_CNT, c);
        wr(A_CMP, c + 16'd10);
        repeat (8) @(negedge clk);
        wr(A_CMP, c + 16'd20);
        chk_reg(A_FLG, 16'h0010, "R7 old value still matches");
        chk_reg(A_CMP, c + 16'd20, "R7 new value stored");
        repeat (9) @(negedge clk);
        wr(A_FLG, 16'h0010);
        chk_reg(A_FLG, 16'h0010, "R5 R7 set wins over clear at new match");
        wr(A_FLG, 16'h0010);
        chk_reg(A_FLG, 16'h0000, "R5 clear after collision");

        // R8 periodic reload across the wrap
        @(negedge clk);
        rd(A_CNT, c);
        base = c + 16'd5;
        wr(A_CMP, base);
        repeat (4) @(negedge clk);
        chk_irq(1'b1, "R8 first match");
        for (int k = 1; k <= 2; k++) begin
            wr(A_CMP, base + PERIOD * 16'(k));
            wr(A_FLG, 16'h0010);
            repeat (39319) @(negedge clk);
            chk_irq(1'b0, "R8 one step before period");
            @(negedge clk);
            chk_irq(1'b1, "R8 match after period");
        end
        chk_reg(A_CNT, base + PERIOD * 16'd2, "R2 R8 count after wrap");

        #1;
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule